// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration image into a target FPGA over a passive serial link, in hardware, without a processor toggling pins. A host writes the total image length and a one-cycle start pulse. The loader then pulses the target's active-low configuration-reset pin, confirms that the target has acknowledged it, and waits for the target to become ready. It accepts image bytes one at a time from a valid/ready byte stream and shifts each one out on a data pin, paced by a serial clock. When all bytes have been sent it checks the target's configuration-complete pin and issues a burst of extra clocks.

All pin timings come from the clock-frequency parameter. These are the reset pulse width, the settle gap, the readiness timeout and the serial clock half-period. The serial clock is never faster than `DCLK_MAX_HZ`. The two target status inputs pass through two-stage synchronizers before use. The host can cancel at any time, and the block reports busy, done, error and a 2-bit error code.

Top module: `ps_cfg_master`

## Requirements
- R1: Out of reset and while idle, cfgN is high, dclk and data0 are low, and busy, done, error, inReady are low with errCode 0.
- R2: A start pulse while idle raises busy and drives cfgN low for exactly PULSE_US microseconds of clock cycles (400 cycles at 200 MHz, 2 us). dclk stays low while cfgN is low.
- R3: If the synchronized statusN input is not low when the reset pulse ends, the load aborts with error high and errCode 1.
- R4: After cfgN rises, the block waits GAP_US microseconds and then waits for statusN to go high. If statusN does not go high within TIMEOUT_US microseconds, the load aborts with errCode 2, so busy lasts at least the pulse, gap and timeout together.
- R5: Each byte is sent least significant bit first, one bit per dclk rising edge. data0 changes only while dclk is low.
- R6: Every dclk high phase and low phase lasts at least ceil(CLK_HZ / (2*DCLK_MAX_HZ)) clock cycles (2 at 200 MHz and 50 MHz).
- R7: inReady is high only while the block waits for the next byte. Exactly byteCount bytes are accepted, and inReady falls in the cycle after each accepted byte.
- R8: After the last bit, or right after the ready wait when byteCount is 0, a low confDone input aborts the load with errCode 3, and no further dclk rising edge follows.
- R9: When confDone is high at that check, exactly 12 more dclk pulses follow. Then busy falls with done high, error low and errCode 0.
- R10: A cancel pulse while busy aborts the load: busy falls, error goes high with errCode 0, cfgN goes high and dclk low.
- R11: done, error and errCode hold their values while idle until the next start, which clears them. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CLK_HZ) |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle load request, taken only while idle |
| cancel | input | 1 | Abort request while busy |
| byteCount | input | CNT_W | Number of image bytes, sampled at start |
| inData | input | 8 | Image byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block takes inData on this cycle's edge when inValid is high |
| cfgN | output | 1 | Active-low configuration reset to target |
| dclk | output | 1 | Serial configuration clock to target |
| data0 | output | 1 | Serial configuration data to target |
| statusN | input | 1 | Target status, low while in reset (asynchronous) |
| confDone | input | 1 | Target configuration complete (asynchronous) |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load succeeded |
| error | output | 1 | Last load aborted |
| errCode | output | 2 | Abort reason: 0 cancel, 1 status not low, 2 ready timeout, 3 confDone low |

## Verification
The hardest situation to reach is the readiness timeout, because the target must acknowledge the reset pulse and then never release its status line. The bench's target model has a switch that keeps statusN low after cfgN rises. It measures how long busy stays high against the sum of pulse, gap and timeout, with the timeout shortened to 10 us by parameter. The confDone failure is also hard to reach. It needs a full byte transfer followed by a silent target, and the model reaches it by never raising confDone while still counting every dclk edge, which shows that no trailing clocks leak out.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  // Strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic timerClr;   // restart phase timer
    logic cfgLow;     // drive cfgN low
    logic cfgHigh;    // release cfgN
    logic loadCount;  // capture byte total
    logic loadByte;   // take a byte, present its bit 0, dclk low
    logic nextBit;    // present following bit, dclk low
    logic clkHigh;    // dclk rising
    logic clkLow;     // dclk falling
  } dpCtl_t;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_STATUS   = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT  = 2'd2;
  localparam logic [1:0] ERR_CONFDONE = 2'd3;
endpackage

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             statusN,
  input  logic             confDone,
  output logic [TMR_W-1:0] timer,
  output logic             bytesZero,
  output logic             lastBit,
  output logic             statusSync,
  output logic             doneSync,
  output logic             cfgN,
  output logic             dclk,
  output logic             data0
);
  localparam int SYNC_N = 2;

  logic [CNT_W-1:0] bytesLeft;
  logic [6:0]       shiftReg;
  logic [2:0]       bitIdx;
  logic [1:0]       asyncIn;
  logic [1:0]       syncOut;

  assign asyncIn = {confDone, statusN};

  // Two-stage synchronizer per asynchronous target input
  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_N-1:0] stages;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stages <= '0;
      else       stages <= {stages[SYNC_N-2:0], asyncIn[g]};
    end
    assign syncOut[g] = stages[SYNC_N-1];
  end

  assign statusSync = syncOut[0];
  assign doneSync   = syncOut[1];
  assign bytesZero  = (bytesLeft == '0);
  assign lastBit    = &bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer     <= '0;
      bytesLeft <= '0;
      shiftReg  <= '0;
      bitIdx    <= '0;
      cfgN      <= 1'b1;
      dclk      <= 1'b0;
      data0     <= 1'b0;
    end else begin
      if (ctl.timerClr)     timer <= '0;
      else if (~&timer)     timer <= timer + 1'b1;
      if (ctl.loadCount)    bytesLeft <= byteCount;
      if (ctl.cfgLow)       cfgN <= 1'b0;
      if (ctl.cfgHigh)      cfgN <= 1'b1;
      if (ctl.clkHigh)      dclk <= 1'b1;
      if (ctl.clkLow)       dclk <= 1'b0;
      if (ctl.loadByte) begin
        shiftReg  <= inData[7:1];
        data0     <= inData[0];
        bitIdx    <= '0;
        dclk      <= 1'b0;
        bytesLeft <= bytesLeft - 1'b1;
      end
      if (ctl.nextBit) begin
        data0    <= shiftReg[0];
        shiftReg <= {1'b0, shiftReg[6:1]};
        bitIdx   <= bitIdx + 1'b1;
        dclk     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter int PULSE_CYC = 400,
  parameter int GAP_CYC   = 400,
  parameter int WAIT_CYC  = 2000,
  parameter int HALF_CYC  = 2,
  parameter int TRAIL_N   = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cancel,
  input  logic             inValid,
  input  logic [TMR_W-1:0] timer,
  input  logic             bytesZero,
  input  logic             lastBit,
  input  logic             statusSync,
  input  logic             doneSync,
  output dpCtl_t           ctl,
  output logic             inReady,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [1:0]       errCode
);
  localparam int TRW = $clog2(TRAIL_N + 1);
  localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_END   = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_END  = TMR_W'(WAIT_CYC - 1);
  localparam logic [TMR_W-1:0] HALF_END  = TMR_W'(HALF_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_GAP, S_POLL, S_FETCH, S_LOW, S_HIGH,
    S_DCHK, S_THI, S_TLO
  } state_t;

  state_t         state, nextState;
  logic [TRW-1:0] trail;
  logic           failNow, finish, trailClr, trailInc;
  logic [1:0]     failCode;

  assign busy    = (state != S_IDLE);
  assign inReady = (state == S_FETCH) && !cancel;

  always_comb begin
    ctl       = '0;
    nextState = state;
    failNow   = 1'b0;
    failCode  = ERR_NONE;
    finish    = 1'b0;
    trailClr  = 1'b0;
    trailInc  = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.cfgLow = 1'b1; ctl.timerClr = 1'b1; ctl.loadCount = 1'b1;
        nextState = S_PULSE;
      end
      S_PULSE: if (timer == PULSE_END) begin
        if (!statusSync) begin
          ctl.cfgHigh = 1'b1; ctl.timerClr = 1'b1; nextState = S_GAP;
        end else begin
          failNow = 1'b1; failCode = ERR_STATUS;
        end
      end
      S_GAP: if (timer == GAP_END) begin
        ctl.timerClr = 1'b1; nextState = S_POLL;
      end
      S_POLL: if (statusSync) begin
        ctl.timerClr = 1'b1;
        nextState = bytesZero ? S_DCHK : S_FETCH;
      end else if (timer == WAIT_END) begin
        failNow = 1'b1; failCode = ERR_TIMEOUT;
      end
      S_FETCH: if (inValid) begin
        ctl.loadByte = 1'b1; ctl.timerClr = 1'b1; nextState = S_LOW;
      end
      S_LOW: if (timer == HALF_END) begin
        ctl.clkHigh = 1'b1; ctl.timerClr = 1'b1; nextState = S_HIGH;
      end
      S_HIGH: if (timer == HALF_END) begin
        ctl.timerClr = 1'b1;
        if (!lastBit) begin
          ctl.nextBit = 1'b1; nextState = S_LOW;
        end else if (bytesZero) begin
          ctl.clkLow = 1'b1; nextState = S_DCHK;
        end else begin
          nextState = S_FETCH;
        end
      end
      S_DCHK: if (timer == HALF_END) begin
        if (doneSync) begin
          ctl.clkHigh = 1'b1; ctl.timerClr = 1'b1; trailClr = 1'b1;
          nextState = S_THI;
        end else begin
          failNow = 1'b1; failCode = ERR_CONFDONE;
        end
      end
      S_THI: if (timer == HALF_END) begin
        ctl.clkLow = 1'b1; ctl.timerClr = 1'b1; nextState = S_TLO;
      end
      S_TLO: if (timer == HALF_END) begin
        if (trail == TRW'(TRAIL_N - 1)) begin
          finish = 1'b1; nextState = S_IDLE;
        end else begin
          trailInc = 1'b1; ctl.clkHigh = 1'b1; ctl.timerClr = 1'b1;
          nextState = S_THI;
        end
      end
      default: nextState = S_IDLE;
    endcase
    if (busy && cancel) begin
      failNow  = 1'b1;
      failCode = ERR_NONE;
      finish   = 1'b0;
    end
    if (failNow) begin
      ctl         = '0;
      ctl.cfgHigh = 1'b1;
      ctl.clkLow  = 1'b1;
      nextState   = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      trail   <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= nextState;
      if (trailClr)      trail <= '0;
      else if (trailInc) trail <= trail + 1'b1;
      if (state == S_IDLE && start) begin
        done <= 1'b0; error <= 1'b0; errCode <= ERR_NONE;
      end
      if (finish) done <= 1'b1;
      if (failNow) begin
        error <= 1'b1; errCode <= failCode;
      end
    end
  end
endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int DCLK_MAX_HZ = 50_000_000,
  parameter int PULSE_US    = 2,
  parameter int GAP_US      = 2,
  parameter int TIMEOUT_US  = 100_000,
  parameter int TRAIL_N     = 12,
  parameter int CNT_W       = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cancel,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             cfgN,
  output logic             dclk,
  output logic             data0,
  input  logic             statusN,
  input  logic             confDone,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [1:0]       errCode
);
  localparam int CYC_US    = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PULSE_CYC = (PULSE_US < 1) ? CYC_US : PULSE_US * CYC_US;
  localparam int GAP_CYC   = (GAP_US < 1) ? CYC_US : GAP_US * CYC_US;
  localparam int WAIT_CYC  = (TIMEOUT_US < 1) ? CYC_US : TIMEOUT_US * CYC_US;
  localparam int HALF_RAW  = (CLK_HZ + 2 * DCLK_MAX_HZ - 1) / (2 * DCLK_MAX_HZ);
  localparam int HALF_CYC  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int TMR_W     = $clog2(PULSE_CYC + GAP_CYC + WAIT_CYC + HALF_CYC + 1);

  dpCtl_t           ctl;
  logic [TMR_W-1:0] timer;
  logic             bytesZero, lastBit, statusSync, doneSync;

  ps_cfg_ctrl #(
    .TMR_W(TMR_W), .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC),
    .WAIT_CYC(WAIT_CYC), .HALF_CYC(HALF_CYC), .TRAIL_N(TRAIL_N)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .cancel(cancel),
    .inValid(inValid), .timer(timer), .bytesZero(bytesZero),
    .lastBit(lastBit), .statusSync(statusSync), .doneSync(doneSync),
    .ctl(ctl), .inReady(inReady), .busy(busy), .done(done),
    .error(error), .errCode(errCode)
  );

  ps_cfg_datapath #(.CNT_W(CNT_W), .TMR_W(TMR_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .byteCount(byteCount),
    .inData(inData), .statusN(statusN), .confDone(confDone),
    .timer(timer), .bytesZero(bytesZero), .lastBit(lastBit),
    .statusSync(statusSync), .doneSync(doneSync),
    .cfgN(cfgN), .dclk(dclk), .data0(data0)
  );
endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int DCLK_MAX_HZ = 50_000_000
) (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       cancel,
  input logic       inValid,
  input logic       inReady,
  input logic       cfgN,
  input logic       dclk,
  input logic       data0,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [1:0] errCode
);
  localparam int HALF_RAW = (CLK_HZ + 2 * DCLK_MAX_HZ - 1) / (2 * DCLK_MAX_HZ);
  localparam int HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic [7:0] hiLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        hiLen <= '0;
    else if (!dclk)   hiLen <= '0;
    else if (~&hiLen) hiLen <= hiLen + 1'b1;
  end

  // R2
  quiet_clock_in_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgN |-> !dclk);

  // R5
  data_moves_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(data0) |-> !dclk);

  // R6
  dclk_high_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dclk) |-> (hiLen >= 8'(HALF_CYC)));

  // R7
  ready_drops_after_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> !inReady);

  // R9
  success_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && !error && errCode == 2'd0));

  // R10
  cancel_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cancel) |=> (!busy && error && errCode == 2'd0 && cfgN && !dclk));

  // R11
  status_holds_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!busy) && !$past(start)) |-> ($stable(errCode) && $stable(done) && $stable(error)));
endmodule

bind ps_cfg_master ps_cfg_master_chk #(.CLK_HZ(CLK_HZ), .DCLK_MAX_HZ(DCLK_MAX_HZ)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .cancel(cancel), .inValid(inValid),
  .inReady(inReady), .cfgN(cfgN), .dclk(dclk), .data0(data0), .busy(busy),
  .done(done), .error(error), .errCode(errCode)
);

// File: tb/ps_cfg_master_test.sv
module ps_cfg_master_test;
  localparam int CNT_W      = 16;
  localparam int PULSE_CYC  = 400;
  localparam int GAP_CYC    = 400;
  localparam int WAIT_CYC   = 2000;
  localparam int HALF_CYC   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, cancel = 1'b0, inValid = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0] inData = '0;
  logic inReady, cfgN, dclk, data0, busy, done, error;
  logic [1:0] errCode;
  logic statusN = 1'b1, confDone = 1'b0;

  always #2.5 clk = ~clk;

  ps_cfg_master #(
    .CLK_HZ(200_000_000), .DCLK_MAX_HZ(50_000_000), .PULSE_US(2),
    .GAP_US(2), .TIMEOUT_US(10), .TRAIL_N(12), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .cancel(cancel),
    .byteCount(byteCount), .inData(inData), .inValid(inValid),
    .inReady(inReady), .cfgN(cfgN), .dclk(dclk), .data0(data0),
    .statusN(statusN), .confDone(confDone), .busy(busy), .done(done),
    .error(error), .errCode(errCode)
  );

  int errors = 0, checks = 0;
  logic [7:0] txBytes [8];
  logic [7:0] rxBytes [8];

  // target model controls and observations
  bit stuckHigh = 0, neverRel = 0, confNever = 0;
  int expN = 0, rxBits = 0, trailRises = 0, lowCnt = 0, lastPulse = 0;
  int relCnt = 0, accCnt = 0, busyCnt = 0, hiCnt = 0, hiBad = 0;
  logic prevDclk = 1'b0, prevCfg = 1'b1;

  always @(negedge clk) begin
    if (!rstN) begin
      statusN = 1'b1; confDone = 1'b0; rxBits = 0; trailRises = 0;
      lowCnt = 0; lastPulse = 0; relCnt = 0; accCnt = 0; busyCnt = 0;
      hiCnt = 0; hiBad = 0; prevDclk = 1'b0; prevCfg = 1'b1;
    end else begin
      if (start && !busy) busyCnt = 0;
      if (busy) busyCnt++;
      if (inValid && inReady) accCnt++;
      if (!cfgN) lowCnt++;
      if (cfgN && !prevCfg) begin lastPulse = lowCnt; lowCnt = 0; end
      if (dclk && !prevDclk) begin
        if (confDone) trailRises++;
        else begin
          if (rxBits < 64) rxBytes[rxBits/8][rxBits%8] = data0;
          rxBits++;
        end
      end
      if (dclk) hiCnt++;
      else begin
        if (prevDclk && hiCnt < HALF_CYC) hiBad++;
        hiCnt = 0;
      end
      if (!cfgN) begin
        statusN = stuckHigh; relCnt = 0; confDone = 1'b0;
        rxBits = 0; trailRises = 0; accCnt = 0;
      end else begin
        if (relCnt < 20) relCnt++;
        else if (!neverRel) statusN = 1'b1;
        if (rxBits == 8 * expN && !confNever) confDone = 1'b1;
      end
      prevDclk = dclk;
      prevCfg = cfgN;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; start = 0; cancel = 0; inValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startLoad(input int n);
    @(negedge clk);
    expN = n; byteCount = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      inData = txBytes[i]; inValid = 1'b1;
      while (!inReady) @(negedge clk);
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    check(cfgN == 1'b1, "R1", "cfgN idle", cfgN, 1);
    check(dclk == 1'b0 && data0 == 1'b0, "R1", "dclk/data0 idle", dclk, 0);
    check(!busy && !done && !error, "R1", "status idle", {busy, done, error}, 0);
    check(!inReady && errCode == 2'd0, "R1", "inReady/errCode idle", inReady, 0);
  endtask

  task automatic testNormal();
    stuckHigh = 0; neverRel = 0; confNever = 0;
    txBytes[0] = 8'hA5; txBytes[1] = 8'h3C; txBytes[2] = 8'h81;
    startLoad(3);
    check(busy == 1'b1 && cfgN == 1'b0, "R2", "busy and cfgN low after start", busy, 1);
    feed(3);
    waitIdle();
    check(lastPulse == PULSE_CYC, "R2", "cfgN low cycles", lastPulse, PULSE_CYC);
    for (int i = 0; i < 3; i++)
      check(rxBytes[i] == txBytes[i], "R5", "received byte LSB first", rxBytes[i], txBytes[i]);
    check(accCnt == 3, "R7", "bytes accepted", accCnt, 3);
    check(!inReady, "R7", "inReady low when idle", inReady, 0);
    check(hiBad == 0, "R6", "short dclk high phases", hiBad, 0);
    check(trailRises == 12, "R9", "trailing pulses", trailRises, 12);
    check(done && !error && errCode == 2'd0, "R9", "done status", {done, error, errCode}, 4'b1000);
    check(cfgN && !dclk, "R9", "pins after success", {cfgN, dclk}, 2);
  endtask

  task automatic testZeroLen();
    startLoad(0);
    waitIdle();
    check(rxBits == 0, "R9", "no data bits on empty load", rxBits, 0);
    check(trailRises == 12, "R9", "trailing pulses on empty load", trailRises, 12);
    check(done && !error, "R9", "empty load done", done, 1);
  endtask

  task automatic testStatusStuck();
    stuckHigh = 1;
    startLoad(1);
    waitIdle();
    check(error && errCode == 2'd1, "R3", "status not low code", errCode, 1);
    check(!done && cfgN && rxBits == 0, "R3", "no data after status fault", rxBits, 0);
    repeat (5) @(negedge clk);
    check(error && errCode == 2'd1, "R11", "error holds while idle", errCode, 1);
  endtask

  task automatic testRestart();
    stuckHigh = 0;
    txBytes[0] = 8'h5E;
    startLoad(1);
    check(!error && errCode == 2'd0, "R11", "start clears error", errCode, 0);
    repeat (50) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    feed(1);
    waitIdle();
    check(lastPulse == PULSE_CYC, "R11", "start while busy ignored (pulse width)", lastPulse, PULSE_CYC);
    check(rxBytes[0] == 8'h5E && done, "R5", "single byte after restart", rxBytes[0], 8'h5E);
  endtask

  task automatic testTimeout();
    neverRel = 1;
    startLoad(1);
    waitIdle();
    check(error && errCode == 2'd2, "R4", "ready timeout code", errCode, 2);
    check(busyCnt >= PULSE_CYC + GAP_CYC + WAIT_CYC, "R4", "busy span before timeout",
          busyCnt, PULSE_CYC + GAP_CYC + WAIT_CYC);
    neverRel = 0;
  endtask

  task automatic testConfDoneLow();
    confNever = 1;
    txBytes[0] = 8'h12; txBytes[1] = 8'hF0;
    startLoad(2);
    feed(2);
    waitIdle();
    check(error && errCode == 2'd3, "R8", "confDone low code", errCode, 3);
    check(rxBits == 16, "R8", "no dclk edges past data", rxBits, 16);
    check(!done && cfgN && !dclk, "R8", "pins after confDone fault", {done, cfgN, dclk}, 2);
    confNever = 0;
  endtask

  task automatic testCancel();
    txBytes[0] = 8'h77;
    startLoad(3);
    feed(1);
    repeat (10) @(negedge clk);
    cancel = 1'b1; @(negedge clk); cancel = 1'b0;
    check(!busy && error && errCode == 2'd0, "R10", "cancel abort status", errCode, 0);
    check(cfgN && !dclk && !done, "R10", "cancel pins", {cfgN, dclk}, 2);
    check(!inReady, "R10", "no request after cancel", inReady, 0);
  endtask

  bit finished = 0;

  initial begin
    testReset();
    testNormal();
    testZeroLen();
    testStatusStuck();
    testRestart();
    testTimeout();
    testConfDoneLow();
    testCancel();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule